// File: doc/BRIEF.md
# Fetch-Address Branch Target Buffer

This block sits at the head of an instruction fetch loop. Every cycle it takes the address being fetched and, one cycle later, gives the address to fetch next. The fetch loop can feed that address straight back in, so a chain of taken branches can be followed at one per cycle. The block needs nothing from decode. It is a two-way set-associative table of branch targets. Each entry is found through index bits of the fetch address and confirmed by a partial tag. When an entry matches, its stored target is the prediction. When no entry matches, the prediction is the next sequential fetch block, which amounts to predicting not-taken.

Branch resolution sends its results back many cycles later on a separate update port, with no timing tie to the lookups. An update carries the branch address, the actual outcome and the actual target. A branch gets an entry only once it has been seen taken, so branches that always fall through use no table space. A resolved not-taken outcome for a branch that holds an entry removes that entry.

The address map is fixed by the default parameters. Fetch blocks are 16 bytes. Bits [7:4] select one of 16 sets. Bits [15:8] form the 8-bit partial tag. Bits [3:0] and bits above 15 play no part in matching.

Top module: `btb_fetch_predictor`

## Requirements
- R1: While reset is low and on the first edges after it, `pred_hit` is 0 and `pred_next_pc` is 0. Reset clears every entry, so any lookup made after reset misses until an entry has been allocated.
- R2: The prediction for a `fetch_pc` appears on `pred_hit`/`pred_next_pc` after exactly one rising clock edge. Before that edge the outputs still show the previous lookup.
- R3: On a miss, `pred_hit` is 0 and `pred_next_pc` is `fetch_pc` with bits [3:0] cleared, plus 16.
- R4: After an update with `upd_taken`=1, a lookup of an address with the same bits [15:4] gives `pred_hit`=1 and `pred_next_pc` equal to the stored target.
- R5: An address with the same set bits [7:4] but different tag bits [15:8] does not pick up another branch's target. It misses.
- R6: A not-taken update for a branch that has no entry allocates nothing. A later lookup of that address still misses.
- R7: A not-taken update for a branch that has an entry invalidates that entry. A later lookup of that address misses.
- R8: Two branches in the same set are both held. A taken update that misses places the new entry in an invalid way first. If both ways are valid, it evicts the way that was not most recently written by a taken update.
- R9: A taken update for a branch that already has an entry overwrites its target in place and marks that way as most recently written. No second entry is created.
- R10: When a lookup and an update touch the same set in the same cycle, the lookup uses the contents from before the update.
- R11: A lookup made in the cycle after an update's clock edge sees that update.
- R12: Address bits above bit 15 are not compared. Two addresses that differ only there give the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | Address fetched this cycle |
| pred_hit | output | 1 | Registered: the last lookup matched an entry |
| pred_next_pc | output | 32 | Registered: predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 means taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The hardest state to reach is a set where the replacement bit points at a valid way while the other way sits invalid. This is the only state that shows invalid-first allocation working apart from the LRU choice. The stimulus builds it in steps. It fills one way, adds a branch to the other, invalidates that second branch with a not-taken outcome, and only then sends a new taken branch. Because updates are presented in the same cycle as lookups, the old-contents ordering of same-set collisions is checked as well, including a target refresh in which the lookup must still return the old target.

// File: rtl/btb_pkg.sv
// Package: shared constants and the update-action encoding for the
// fetch-address branch target buffer. Assumes a two-way organisation
// with a single replacement bit per set.
package btb_pkg;
    localparam int BTB_WAYS = 2;

    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_WRITE = 2'd1,
        UPD_KILL  = 2'd2
    } upd_action_e;
endpackage

// File: rtl/btb_way_store.sv
// Module: one way of the target table. Holds a valid bit, partial tag and
// full target for each set. Has one combinational read port for the fetch
// lookup, one combinational read port for the update side, and one write
// port used either to write an entry or to invalidate it. Assumes the
// caller never asserts write and kill together.
module btb_way_store #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_valid,
    output logic [TAG_W-1:0]  look_tag,
    output logic [ADDR_W-1:0] look_target,
    input  logic [IDX_W-1:0]  upd_idx,
    output logic              upd_valid_rd,
    output logic [TAG_W-1:0]  upd_tag_rd,
    input  logic              wr_en,
    input  logic              kill_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [ADDR_W-1:0] tgt_mem [SETS];

    // Purpose: valid bits, cleared by reset, set on write, cleared on kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[upd_idx] <= 1'b1;
        end else if (kill_en) begin
            valid_q[upd_idx] <= 1'b0;
        end
    end

    // Purpose: tag and target storage, written only on allocation or refresh.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[upd_idx] <= wr_tag;
            tgt_mem[upd_idx] <= wr_target;
        end
    end

    // Purpose: lookup-side read of the current (pre-edge) contents.
    always_comb begin
        look_valid  = valid_q[look_idx];
        look_tag    = tag_mem[look_idx];
        look_target = tgt_mem[look_idx];
    end

    // Purpose: update-side read used for hit detection before a write.
    always_comb begin
        upd_valid_rd = valid_q[upd_idx];
        upd_tag_rd   = tag_mem[upd_idx];
    end
endmodule

// File: rtl/btb_victim_pick.sv
// Module: chooses the way that receives a new allocation. An invalid way is
// taken first, the lower-numbered one if both are invalid. Otherwise the
// set's replacement bit, which names the least recently written way, decides.
module btb_victim_pick (
    input  logic [1:0] way_valid,
    input  logic       repl_way,
    output logic       victim_way
);
    // Purpose: invalid-first, then replacement-bit victim selection.
    always_comb begin
        if (!way_valid[0]) begin
            victim_way = 1'b0;
        end else if (!way_valid[1]) begin
            victim_way = 1'b1;
        end else begin
            victim_way = repl_way;
        end
    end
endmodule

// File: rtl/btb_fetch_predictor.sv
// Module: top of the fetch-address branch target buffer. Each cycle it looks
// up fetch_pc and registers a next-fetch prediction: the stored target on a
// tag match, otherwise the next sequential block. Resolved branches update
// the table on a separate port. Taken outcomes allocate or refresh an entry,
// and not-taken outcomes that match an entry invalidate it. Assumes at most
// one update per cycle. A lookup colliding with an update reads the old
// contents.
module btb_fetch_predictor #(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 16,
    parameter int TAG_W       = 8,
    parameter int BLOCK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    import btb_pkg::*;

    localparam int WAYS   = BTB_WAYS;
    localparam int IDX_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int TAG_LO = OFF_W + IDX_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam logic [BLK_W-1:0] BLK_ONE = {{(BLK_W-1){1'b0}}, 1'b1};

    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [IDX_W-1:0]  upd_idx;
    logic [TAG_W-1:0]  upd_tag;

    logic [WAYS-1:0]   look_valid_v;
    logic [TAG_W-1:0]  look_tag_v  [WAYS];
    logic [ADDR_W-1:0] look_tgt_v  [WAYS];
    logic [WAYS-1:0]   look_hit_vec;
    logic [WAYS-1:0]   upd_valid_v;
    logic [TAG_W-1:0]  upd_tag_v   [WAYS];
    logic [WAYS-1:0]   upd_hit_vec;
    logic [WAYS-1:0]   way_wr_en;
    logic [WAYS-1:0]   way_kill_en;

    logic [SETS-1:0]   repl_q;
    logic              victim_way;
    logic              upd_hit_way;
    logic              sel_way;
    upd_action_e       action;

    logic              hit_comb;
    logic [ADDR_W-1:0] hit_target;
    logic [ADDR_W-1:0] seq_pc;
    logic [BLK_W-1:0]  next_blk;

    // Purpose: split lookup and update addresses into set index and tag.
    always_comb begin
        look_idx = fetch_pc[OFF_W +: IDX_W];
        look_tag = fetch_pc[TAG_LO +: TAG_W];
        upd_idx  = upd_pc[OFF_W +: IDX_W];
        upd_tag  = upd_pc[TAG_LO +: TAG_W];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        btb_way_store #(
            .SETS   (SETS),
            .TAG_W  (TAG_W),
            .ADDR_W (ADDR_W)
        ) way_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .look_idx     (look_idx),
            .look_valid   (look_valid_v[w]),
            .look_tag     (look_tag_v[w]),
            .look_target  (look_tgt_v[w]),
            .upd_idx      (upd_idx),
            .upd_valid_rd (upd_valid_v[w]),
            .upd_tag_rd   (upd_tag_v[w]),
            .wr_en        (way_wr_en[w]),
            .kill_en      (way_kill_en[w]),
            .wr_tag       (upd_tag),
            .wr_target    (upd_target)
        );

        // Purpose: per-way tag compare for the lookup and update sides.
        always_comb begin
            look_hit_vec[w] = look_valid_v[w] && (look_tag_v[w] == look_tag);
            upd_hit_vec[w]  = upd_valid_v[w] && (upd_tag_v[w] == upd_tag);
        end
    end

    // Purpose: select the matching way's target for the lookup.
    always_comb begin
        hit_comb   = 1'b0;
        hit_target = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (look_hit_vec[w]) begin
                hit_comb   = 1'b1;
                hit_target = look_tgt_v[w];
            end
        end
    end

    // Purpose: sequential fall-through address, next aligned fetch block.
    always_comb begin
        next_blk = fetch_pc[ADDR_W-1:OFF_W] + BLK_ONE;
        seq_pc   = {next_blk, {OFF_W{1'b0}}};
    end

    btb_victim_pick victim_i (
        .way_valid  (upd_valid_v),
        .repl_way   (repl_q[upd_idx]),
        .victim_way (victim_way)
    );

    // Purpose: classify the update and pick the way it acts on.
    always_comb begin
        upd_hit_way = upd_hit_vec[1];
        action      = UPD_NONE;
        if (upd_valid) begin
            if (upd_taken) begin
                action = UPD_WRITE;
            end else if (|upd_hit_vec) begin
                action = UPD_KILL;
            end
        end
        sel_way = (action == UPD_WRITE && !(|upd_hit_vec)) ? victim_way
                                                           : upd_hit_way;
    end

    // Purpose: drive per-way write and kill enables from the action.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            way_wr_en[w]   = (action == UPD_WRITE) && (sel_way == w[0]);
            way_kill_en[w] = (action == UPD_KILL) && (sel_way == w[0]);
        end
    end

    // Purpose: replacement bit per set names the way not written last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repl_q <= '0;
        end else if (action == UPD_WRITE) begin
            repl_q[upd_idx] <= ~sel_way;
        end
    end

    // Purpose: register the prediction one cycle after the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_hit     <= 1'b0;
            pred_next_pc <= '0;
        end else begin
            pred_hit     <= hit_comb;
            pred_next_pc <= hit_comb ? hit_target : seq_pc;
        end
    end
endmodule

// File: rtl/btb_fetch_predictor_chk.sv
// Module: assertion checker for btb_fetch_predictor, attached by bind.
// Watches only ports plus the lookup hit vector. Assumes the default
// address map (16-byte blocks) is derived from the same parameters.
module btb_fetch_predictor_chk #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target,
    input logic [1:0]        look_hit_vec
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam logic [BLK_W-1:0] BLK_ONE = {{(BLK_W-1){1'b0}}, 1'b1};

    logic              live_q;
    logic              seen_taken_q;
    logic [ADDR_W-1:0] prev_fetch_q;
    logic [BLK_W-1:0]  exp_blk;
    logic [ADDR_W-1:0] exp_seq;

    // Purpose: track one full cycle out of reset, a taken update, last fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q       <= 1'b0;
            seen_taken_q <= 1'b0;
        end else begin
            live_q       <= 1'b1;
            seen_taken_q <= seen_taken_q | (upd_valid & upd_taken);
        end
        prev_fetch_q <= fetch_pc;
    end

    // Purpose: expected sequential address of the previous lookup.
    always_comb begin
        exp_blk = prev_fetch_q[ADDR_W-1:OFF_W] + BLK_ONE;
        exp_seq = {exp_blk, {OFF_W{1'b0}}};
    end

    // R3: a miss predicts the next aligned block.
    a_r3_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !pred_hit) |-> (pred_next_pc == exp_seq));

    // R6: no hit is possible before any taken outcome was seen.
    a_r6_hit_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> seen_taken_q);

    // R4, R11: a taken update is visible to a lookup in the next cycle.
    a_r4_taken_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) ##1 (!upd_valid && fetch_pc == $past(upd_pc))
        |=> (pred_hit && pred_next_pc == $past(upd_target, 2)));

    // R7: a not-taken update leaves the branch without an entry.
    a_r7_not_taken_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) ##1 (!upd_valid && fetch_pc == $past(upd_pc))
        |=> !pred_hit);

    // R5, R9: allocation never leaves two ways holding the same branch.
    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hit_vec));
endmodule

bind btb_fetch_predictor btb_fetch_predictor_chk #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .look_hit_vec (look_hit_vec)
);

// File: tb/btb_fetch_predictor_tb_top.sv
module btb_fetch_predictor_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        uv;
        logic [31:0] upc;
        logic        ut;
        logic [31:0] utg;
        logic [31:0] fpc;
        logic        eh;
        logic [31:0] en;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    // Each row: update fields, lookup address, expected hit/next, requirement.
    // Expectations use contents before that row's own update (R10).
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h123C,      1'b0, 32'h1240, 8'd3},  // R3 miss, low bits
        '{1'b1, 32'h1234,   1'b1, 32'h8000, 32'h1230,      1'b0, 32'h1240, 8'd10}, // R10 old contents
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1230,      1'b1, 32'h8000, 8'd4},  // R4/R11 hit
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b0, 32'h5540, 8'd5},  // R5 tag alias
        '{1'b1, 32'h5534,   1'b0, 32'h0,    32'h5530,      1'b0, 32'h5540, 8'd6},  // R6 nt miss
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b0, 32'h5540, 8'd6},  // R6 none allocated
        '{1'b1, 32'h5538,   1'b1, 32'h9000, 32'h0,         1'b0, 32'h10,   8'd3},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b1, 32'h9000, 8'd8},  // R8 both held
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1230,      1'b1, 32'h8000, 8'd8},
        '{1'b1, 32'h7730,   1'b1, 32'hA000, 32'h7730,      1'b0, 32'h7740, 8'd10},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1230,      1'b0, 32'h1240, 8'd8},  // R8 LRU evicted
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b1, 32'h9000, 8'd8},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h7730,      1'b1, 32'hA000, 8'd4},
        '{1'b1, 32'h5530,   1'b1, 32'hB000, 32'h5530,      1'b1, 32'h9000, 8'd10}, // R10 old target
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b1, 32'hB000, 8'd9},  // R9 refreshed
        '{1'b1, 32'h1230,   1'b1, 32'hC000, 32'h0,         1'b0, 32'h10,   8'd3},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h7730,      1'b0, 32'h7740, 8'd9},  // R9 refresh protected
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b1, 32'hB000, 8'd9},
        '{1'b1, 32'h5530,   1'b0, 32'h0,    32'h1230,      1'b1, 32'hC000, 8'd7},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b0, 32'h5540, 8'd7},  // R7 invalidated
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'hABCD_1230, 1'b1, 32'hC000, 8'd12}, // R12 upper bits
        '{1'b1, 32'h7730,   1'b1, 32'hD000, 32'h0,         1'b0, 32'h10,   8'd3},
        '{1'b1, 32'h7730,   1'b0, 32'h0,    32'h0,         1'b0, 32'h10,   8'd3},
        '{1'b1, 32'h5530,   1'b1, 32'hE000, 32'h1240,      1'b0, 32'h1250, 8'd5},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1230,      1'b1, 32'hC000, 8'd8},  // R8 invalid first
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h5530,      1'b1, 32'hE000, 8'd8},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h7730,      1'b0, 32'h7740, 8'd7},
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'hFFFF_FFF8, 1'b0, 32'h0,    8'd3}   // R3 wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    btb_fetch_predictor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_next_pc (pred_next_pc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_target   (upd_target)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, sample just after the next rising edge.
    task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                        input logic [31:0] utg, input logic [31:0] fpc);
        @(negedge clk);
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = ut;
        upd_target = utg;
        fetch_pc   = fpc;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset.
        repeat (3) @(posedge clk);
        #1;
        check(1, "hit in reset", {31'b0, pred_hit}, 32'h0);
        check(1, "next in reset", pred_next_pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].uv, VECS[i].upc, VECS[i].ut, VECS[i].utg, VECS[i].fpc);
            check(int'(VECS[i].req), "hit", {31'b0, pred_hit}, {31'b0, VECS[i].eh});
            check(int'(VECS[i].req), "next", pred_next_pc, VECS[i].en);
        end

        // R1: reset mid-run clears all entries.
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h1230);
        check(1, "hit after reset", {31'b0, pred_hit}, 32'h0);
        check(1, "next after reset", pred_next_pc, 32'h1240);

        // R2: output changes only on the edge after the lookup.
        step(1'b1, 32'h2220, 1'b1, 32'h4444, 32'h3330);
        @(negedge clk);
        upd_valid = 1'b0;
        fetch_pc  = 32'h2220;
        #1;
        check(2, "before edge", pred_next_pc, 32'h3340);
        @(posedge clk);
        #1;
        check(2, "after edge", pred_next_pc, 32'h4444);
        check(2, "hit after edge", {31'b0, pred_hit}, 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule